// File: doc/BRIEF.md
# Sorted Insertion Network

This block merges one incoming value into a list of values that is already held in ascending order. It returns the enlarged list, one entry longer, again in ascending order. It has no clock and no state. The outputs follow the inputs through logic alone, so the caller can register the result wherever its own timing allows.

The incoming value is compared with every stored entry at the same time. This gives one "greater than" flag per entry. When the list is sorted, the flags form a thermometer code: zeros for the entries at or below the new value, then ones. Each output slot reads its own flag and the flag of the slot below it. From these it picks one of three sources: its own stored value, the new value, or the stored value one place lower. The logic depth is one comparator plus one three-way select, whatever the entry count. All values are unsigned. The entry count and the data width are parameters, with defaults of 4 entries of 8 bits.

Top module: `sort_insert_net`

## Requirements
- R1: For any ascending stored list, output slot k (bits k*DATA_W and up) is never larger than slot k+1.
- R2: The outputs are exactly the stored values plus the new value, each kept once: nothing is lost or duplicated.
- R3: A stored value equal to the new value stays in its own slot. The new value is placed after all equal stored values.
- R4: With stored values 4, 6, 7, 9 and new value 5, the outputs are 4, 5, 6, 7, 9.
- R5: A new value below every stored value appears in slot 0, and stored entry i moves to slot i+1.
- R6: A new value at or above every stored value appears in the top slot (slot NUM_ENTRIES), and the lower slots repeat the stored list unchanged.
- R7: Comparison is unsigned: a value with its top bit set (for example 200 or 255 at 8 bits) ranks above every value with that bit clear.
- R8: The outputs respond to an input change with no clock edge involved.
- R9: The top slot always equals the larger of the new value and stored entry NUM_ENTRIES-1.
- R10: Every rule above also holds for non-default parameters (7 entries of 12 bits).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| storedFlat | input | NUM_ENTRIES*DATA_W | Stored list, entry i in bits i*DATA_W and up, ascending with i |
| newVal | input | DATA_W | Value to be inserted |
| sortedFlat | output | (NUM_ENTRIES+1)*DATA_W | Merged list, slot k in bits k*DATA_W and up, ascending with k |

## Verification
The bench targets ties, where the new value equals one or more stored entries. A design that sets a flag on equality would still give correct values, but the built-in checks would see equal entries move. A new value below or above the whole list exercises the first and last slots. A design that gets the thermometer edge wrong at either end would drop one value and repeat another. Values with the top bit set catch a signed comparison, which would rank 200 below 100. Lists built from a narrow value range create runs of duplicates. A wider, longer second instance shows that the select rules do not depend on the defaults.

// File: rtl/sort_insert_pkg.sv
package sort_insert_pkg;

  // Per-slot source select, exactly one bit set.
  typedef struct packed {
    logic keepOwn;   // slot keeps stored entry at the same index
    logic pickNew;   // slot takes the incoming value
    logic pickPrev;  // slot takes stored entry one index lower
  } laneSel_t;

endpackage

// File: rtl/insert_ctrl.sv
module insert_ctrl
  import sort_insert_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int DATA_W      = 8
) (
  input  logic [NUM_ENTRIES*DATA_W-1:0] storedFlat,
  input  logic [DATA_W-1:0]             newVal,
  output laneSel_t [NUM_ENTRIES:0]      laneSel
);

  localparam int LANES = NUM_ENTRIES + 1;

  logic [NUM_ENTRIES-1:0] exceeds;

  // One comparator per stored entry, all in parallel.
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
    assign exceeds[e] = storedFlat[e*DATA_W +: DATA_W] > newVal;
  end

  // Select strobes decoded from the thermometer edge.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k == 0) begin : g_first
      assign laneSel[k].keepOwn  = ~exceeds[0];
      assign laneSel[k].pickNew  =  exceeds[0];
      assign laneSel[k].pickPrev =  1'b0;
    end else if (k == NUM_ENTRIES) begin : g_top
      assign laneSel[k].keepOwn  =  1'b0;
      assign laneSel[k].pickNew  = ~exceeds[k-1];
      assign laneSel[k].pickPrev =  exceeds[k-1];
    end else begin : g_mid
      assign laneSel[k].keepOwn  = ~exceeds[k];
      assign laneSel[k].pickNew  =  exceeds[k] & ~exceeds[k-1];
      assign laneSel[k].pickPrev =  exceeds[k] &  exceeds[k-1];
    end
  end

  // ---------------- checks ----------------
  logic inSorted;
  always_comb begin
    inSorted = 1'b1;
    for (int i = 1; i < NUM_ENTRIES; i++)
      if (storedFlat[(i-1)*DATA_W +: DATA_W] > storedFlat[i*DATA_W +: DATA_W])
        inSorted = 1'b0;
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      // R2
      lane_onehot_chk: assert ($onehot(laneSel[k]))
        else $error("slot %0d select not one-hot", k);
    end
  end

  always_comb begin
    if (inSorted) begin
      for (int i = 1; i < NUM_ENTRIES; i++) begin
        // R1
        flag_thermo_chk: assert (!exceeds[i-1] || exceeds[i])
          else $error("flag vector not a thermometer at %0d", i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (storedFlat[i*DATA_W +: DATA_W] == newVal) begin
        // R3
        tie_stays_chk: assert (laneSel[i].keepOwn)
          else $error("equal entry %0d was moved", i);
      end
    end
  end

  int newCount;
  always_comb begin
    newCount = 0;
    for (int k = 0; k < LANES; k++)
      if (laneSel[k].pickNew) newCount++;
  end

  always_comb begin
    if (inSorted) begin
      // R2
      single_new_chk: assert (newCount == 1)
        else $error("new value placed %0d times", newCount);
    end
  end

endmodule

// File: rtl/insert_path.sv
module insert_path
  import sort_insert_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int DATA_W      = 8
) (
  input  logic [NUM_ENTRIES*DATA_W-1:0]     storedFlat,
  input  logic [DATA_W-1:0]                 newVal,
  input  laneSel_t [NUM_ENTRIES:0]          laneSel,
  output logic [(NUM_ENTRIES+1)*DATA_W-1:0] sortedFlat
);

  localparam int LANES = NUM_ENTRIES + 1;
  localparam int SUM_W = DATA_W + $clog2(LANES) + 1;

  // One AND-OR select per slot.
  for (genvar k = 0; k < LANES; k++) begin : g_mux
    logic [DATA_W-1:0] ownTerm, prevTerm, newTerm;
    assign newTerm = {DATA_W{laneSel[k].pickNew}} & newVal;
    if (k < NUM_ENTRIES) begin : g_own
      assign ownTerm = {DATA_W{laneSel[k].keepOwn}} & storedFlat[k*DATA_W +: DATA_W];
    end else begin : g_noOwn
      assign ownTerm = '0;
    end
    if (k > 0) begin : g_prev
      assign prevTerm = {DATA_W{laneSel[k].pickPrev}} & storedFlat[(k-1)*DATA_W +: DATA_W];
    end else begin : g_noPrev
      assign prevTerm = '0;
    end
    assign sortedFlat[k*DATA_W +: DATA_W] = ownTerm | prevTerm | newTerm;
  end

  // ---------------- checks ----------------
  logic inSorted;
  logic [SUM_W-1:0] sumIn, sumOut;
  logic [DATA_W-1:0] lastStored, topSlot, topExp;
  always_comb begin
    inSorted = 1'b1;
    sumIn    = SUM_W'(newVal);
    sumOut   = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      sumIn = sumIn + SUM_W'(storedFlat[i*DATA_W +: DATA_W]);
      if (i > 0 && storedFlat[(i-1)*DATA_W +: DATA_W] > storedFlat[i*DATA_W +: DATA_W])
        inSorted = 1'b0;
    end
    for (int k = 0; k < LANES; k++)
      sumOut = sumOut + SUM_W'(sortedFlat[k*DATA_W +: DATA_W]);
    lastStored = storedFlat[(NUM_ENTRIES-1)*DATA_W +: DATA_W];
    topSlot    = sortedFlat[NUM_ENTRIES*DATA_W +: DATA_W];
    topExp     = (newVal > lastStored) ? newVal : lastStored;
  end

  always_comb begin
    if (inSorted) begin
      for (int k = 1; k < LANES; k++) begin
        // R1
        out_ascend_chk: assert (sortedFlat[(k-1)*DATA_W +: DATA_W] <= sortedFlat[k*DATA_W +: DATA_W])
          else $error("slots %0d and %0d out of order", k-1, k);
      end
    end
  end

  always_comb begin
    if (inSorted) begin
      // R2
      value_conserve_chk: assert (sumOut == sumIn)
        else $error("output total %0d differs from input total %0d", sumOut, sumIn);
      // R9
      top_slot_max_chk: assert (topSlot == topExp)
        else $error("top slot %0d, larger input %0d", topSlot, topExp);
    end
  end

endmodule

// File: rtl/sort_insert_net.sv
module sort_insert_net
  import sort_insert_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int DATA_W      = 8
) (
  input  logic [NUM_ENTRIES*DATA_W-1:0]     storedFlat,
  input  logic [DATA_W-1:0]                 newVal,
  output logic [(NUM_ENTRIES+1)*DATA_W-1:0] sortedFlat
);

  laneSel_t [NUM_ENTRIES:0] laneSel;

  insert_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W)) u_ctrl (
    .storedFlat (storedFlat),
    .newVal     (newVal),
    .laneSel    (laneSel)
  );

  insert_path #(.NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W)) u_path (
    .storedFlat (storedFlat),
    .newVal     (newVal),
    .laneSel    (laneSel),
    .sortedFlat (sortedFlat)
  );

endmodule

// File: tb/sort_insert_net_test.sv
module sort_insert_net_test;

  localparam int NA = 4;
  localparam int WA = 8;
  localparam int NB = 7;
  localparam int WB = 12;
  localparam time HALF = 2.5ns;

  logic clk = 1'b0;
  always #(HALF) clk = ~clk;

  logic [NA*WA-1:0]     storedA = '0;
  logic [WA-1:0]        newA    = '0;
  logic [(NA+1)*WA-1:0] outA;
  logic [NB*WB-1:0]     storedB = '0;
  logic [WB-1:0]        newB    = '0;
  logic [(NB+1)*WB-1:0] outB;

  sort_insert_net #(.NUM_ENTRIES(NA), .DATA_W(WA)) uut (
    .storedFlat(storedA), .newVal(newA), .sortedFlat(outA));
  sort_insert_net #(.NUM_ENTRIES(NB), .DATA_W(WB)) uutWide (
    .storedFlat(storedB), .newVal(newB), .sortedFlat(outB));

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int st [16];
  int expv [17];

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference: insert nv after every stored value that is <= nv.
  task automatic buildRef(int n, int nv);
    int pos = 0;
    while (pos < n && st[pos] <= nv) pos++;
    for (int i = 0; i < pos; i++) expv[i] = st[i];
    expv[pos] = nv;
    for (int i = pos; i < n; i++) expv[i+1] = st[i];
  endtask

  task automatic drive(bit wide, int nv);
    if (!wide) begin
      for (int i = 0; i < NA; i++) storedA[i*WA +: WA] = WA'(st[i]);
      newA = WA'(nv);
    end else begin
      for (int i = 0; i < NB; i++) storedB[i*WB +: WB] = WB'(st[i]);
      newB = WB'(nv);
    end
  endtask

  function automatic int slotOf(bit wide, int k);
    return wide ? int'(outB[k*WB +: WB]) : int'(outA[k*WA +: WA]);
  endfunction

  task automatic runCase(bit wide, string req, int nv);
    int n = wide ? NB : NA;
    @(negedge clk);
    drive(wide, nv);
    #1;
    buildRef(n, nv);
    for (int k = 0; k < n; k++) check(req, slotOf(wide, k), expv[k]);
    check("R9 top slot", slotOf(wide, n), expv[n]);
  endtask

  task automatic makeSorted(int n, int range);
    for (int i = 0; i < n; i++) st[i] = int'($urandom % range);
    for (int a = 0; a < n; a++)
      for (int b = 0; b < n - 1 - a; b++)
        if (st[b] > st[b+1]) begin
          int t = st[b]; st[b] = st[b+1]; st[b+1] = t;
        end
  endtask

  initial begin
    void'($urandom(32'd4242));
    // idle state: all zero in, all zero out
    #1;
    for (int k = 0; k <= NA; k++) check("R1 idle zero", slotOf(0, k), 0);

    // R4 worked example
    st[0] = 4; st[1] = 6; st[2] = 7; st[3] = 9;
    runCase(0, "R4 example", 5);

    // R5 new value below everything
    st[0] = 3; st[1] = 10; st[2] = 20; st[3] = 30;
    runCase(0, "R5 new lowest", 1);
    runCase(0, "R5 new zero", 0);

    // R6 new value at or above everything
    st[0] = 1; st[1] = 2; st[2] = 3; st[3] = 4;
    runCase(0, "R6 new highest", 255);
    runCase(0, "R6 equal to max", 4);

    // R3 ties
    st[0] = 5; st[1] = 5; st[2] = 5; st[3] = 8;
    runCase(0, "R3 tie run", 5);
    st[0] = 0; st[1] = 0; st[2] = 0; st[3] = 0;
    runCase(0, "R3 all zero tie", 0);
    st[0] = 255; st[1] = 255; st[2] = 255; st[3] = 255;
    runCase(0, "R3 all max tie", 255);

    // R7 unsigned ordering across the top bit
    st[0] = 0; st[1] = 100; st[2] = 127; st[3] = 128;
    runCase(0, "R7 unsigned", 200);
    runCase(0, "R7 unsigned mid", 120);

    // R8 outputs move with no clock edge in between
    @(posedge clk);
    #0.5;
    st[0] = 10; st[1] = 20; st[2] = 30; st[3] = 40;
    drive(0, 25);
    #0.5;
    check("R8 combinational", slotOf(0, 2), 25);
    check("R8 combinational", slotOf(0, 3), 30);

    // R1 R2 random lists, alternating dense duplicates and full range
    for (int it = 0; it < 400; it++) begin
      int range = (it % 2 == 0) ? 4 : 256;
      makeSorted(NA, range);
      runCase(0, "R1 R2 random", int'($urandom % range));
    end

    // R10 non-default parameters
    for (int it = 0; it < 200; it++) begin
      int range = (it % 3 == 0) ? 5 : 4096;
      makeSorted(NB, range);
      runCase(1, "R10 wide random", int'($urandom % range));
    end
    for (int i = 0; i < NB; i++) st[i] = 4095;
    runCase(1, "R10 wide all max", 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(HALF * 2 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule